// File: doc/BRIEF.md
# TLB Autorefill Page Walker

This block services a translation miss in hardware. When a miss request arrives with the faulting virtual address and a data/instruction side flag, the walker forms the virtual address of the matching page-table entry. It does this by ORing the page-table base value with the faulting address shifted right by ten, then clearing the two low bits. It then sends that address to a TLB probe port. The probe port is a plain lookup at ring 0 for a read, and it can never start another walk. On a hit, the walker reads one 32-bit word from memory at the translated physical address and writes a new TLB entry into one of four autorefill ways.

The refill way is picked by a two-bit counter that is incremented before use, so the first refill after reset lands in way 1. A successful refill also loads the faulting address into the exception-address register. When the probe of the page-table address misses, the walker writes nothing and reports the original miss as a fault. Only one walk runs at a time, and busy stays high from the accepting edge until the done pulse.

Top module: `tlb_refill_walker`

## Requirements
- R1: After reset, busy, lkReqValid, memReqValid, tlbWrEn and doneValid are 0 and excVaddr is 0.
- R2: The probe address on lkReqVaddr equals (ptBase | (missVaddr >> 10)) with bits 1:0 cleared, using the values sampled when the miss was accepted.
- R3: The memory read address memReqAddr equals the physical address returned on lkRspPaddr.
- R4: If the probe returns lkRspHit=0, the walker issues no memory read and no TLB write, raises doneValid with doneFault=1, and leaves excVaddr and the way counter unchanged.
- R5: The written ring tlbWrRing equals bits 5:4 of the fetched entry.
- R6: The written entry uses PPN = entry bits 31:12, attribute = entry bits 3:0, VPN = missVaddr bits 31:12, and the side flag of the miss.
- R7: Each successful refill increments a counter that resets to 0 and writes to way = the new counter value mod 4. Consecutive refills therefore use ways 1, 2, 3, 0, 1.
- R8: On a successful refill, excVaddr takes the faulting virtual address. It changes at no other time.
- R9: busy is high from the cycle after a miss is accepted until the done cycle. A missValid seen while busy is ignored.
- R10: memReqValid and memReqAddr hold steady until memReqReady. tlbWrEn is raised the cycle after memRspValid, and doneValid with doneFault=0 follows one cycle after tlbWrEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Miss request, accepted when idle |
| missVaddr | input | 32 | Faulting virtual address |
| missIsData | input | 1 | 1 for the data side, 0 for the instruction side |
| ptBase | input | 32 | Page-table base value |
| busy | output | 1 | Walk in progress |
| lkReqValid | output | 1 | Probe request |
| lkReqVaddr | output | 32 | Page-table entry virtual address |
| lkRspValid | input | 1 | Probe response |
| lkRspHit | input | 1 | Probe hit with ring-0 read permission |
| lkRspPaddr | input | 32 | Translated physical address |
| memReqValid | output | 1 | Memory read request |
| memReqAddr | output | 32 | Memory read address |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Page-table entry word |
| tlbWrEn | output | 1 | TLB write strobe |
| tlbWrIsData | output | 1 | Side of the TLB to write |
| tlbWrWay | output | 2 | Autorefill way |
| tlbWrVpn | output | 20 | Virtual page number |
| tlbWrPpn | output | 20 | Physical page number |
| tlbWrRing | output | 2 | Ring of the entry |
| tlbWrAttr | output | 4 | Attribute nibble |
| excVaddr | output | 32 | Exception virtual address register |
| doneValid | output | 1 | Walk finished |
| doneFault | output | 1 | Walk failed, original miss stands |

## Verification
The probe request appears the cycle after the miss is accepted. The memory request appears the cycle after the probe response. The TLB write comes one cycle after memory data arrives, and the done pulse comes one cycle after that, with excVaddr already updated on the write edge. A failed probe gives done in the very next cycle. The scoreboard samples every port at the falling edge. It compares each result when its strobe is seen, and it checks that done comes exactly one cycle after the write. It also tracks busy on every cycle of each walk and injects stray misses partway through a walk. Memory ready is delayed by varying amounts to exercise the hold rule.

// File: rtl/walker_pkg.sv
package walker_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_MEMREQ, ST_MEMWAIT, ST_WRITE, ST_DONE
  } walkState_t;

  // Strobes from the control into the datapath
  typedef struct packed {
    logic captureMiss;
    logic capturePaddr;
    logic capturePte;
    logic commitRefill;
  } dpStrobe_t;
endpackage

// File: rtl/walker_ctrl.sv
module walker_ctrl
  import walker_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      missValid,
  input  logic      lkRspValid,
  input  logic      lkRspHit,
  input  logic      memReqReady,
  input  logic      memRspValid,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      lkReqValid,
  output logic      memReqValid,
  output logic      tlbWrEn,
  output logic      doneValid,
  output logic      doneFault
);
  walkState_t stateQ, stateD;
  logic faultQ, faultSet;

  always_comb begin
    stateD   = stateQ;
    strobe   = '0;
    faultSet = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (missValid) begin
        strobe.captureMiss = 1'b1;
        stateD = ST_LOOKUP;
      end
      ST_LOOKUP: if (lkRspValid) begin
        if (lkRspHit) begin
          strobe.capturePaddr = 1'b1;
          stateD = ST_MEMREQ;
        end else begin
          faultSet = 1'b1;
          stateD = ST_DONE;
        end
      end
      ST_MEMREQ: if (memReqReady) stateD = ST_MEMWAIT;
      ST_MEMWAIT: if (memRspValid) begin
        strobe.capturePte = 1'b1;
        stateD = ST_WRITE;
      end
      ST_WRITE: begin
        strobe.commitRefill = 1'b1;
        stateD = ST_DONE;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      faultQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strobe.captureMiss) faultQ <= 1'b0;
      else if (faultSet)      faultQ <= 1'b1;
    end
  end

  assign busy        = (stateQ != ST_IDLE);
  assign lkReqValid  = (stateQ == ST_LOOKUP);
  assign memReqValid = (stateQ == ST_MEMREQ);
  assign tlbWrEn     = (stateQ == ST_WRITE);
  assign doneValid   = (stateQ == ST_DONE);
  assign doneFault   = doneValid & faultQ;

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !doneValid) |=> busy);
  // R9
  single_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lkReqValid, memReqValid, tlbWrEn, doneValid}));
  // R4
  probe_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkReqValid && lkRspValid && !lkRspHit) |=> (doneValid && doneFault));
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);
  // R10
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    tlbWrEn |=> (doneValid && !doneFault));
endmodule

// File: rtl/walker_dp.sv
module walker_dp
  import walker_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_WAYS   = 4,
  localparam int VPN_W     = VA_W - PAGE_SHIFT,
  localparam int WAY_W     = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [VA_W-1:0]  missVaddr,
  input  logic             missIsData,
  input  logic [VA_W-1:0]  ptBase,
  input  logic [VA_W-1:0]  lkRspPaddr,
  input  logic [31:0]      memRspData,
  output logic [VA_W-1:0]  pteVaddr,
  output logic [VA_W-1:0]  memAddr,
  output logic             tlbWrIsData,
  output logic [WAY_W-1:0] tlbWrWay,
  output logic [VPN_W-1:0] tlbWrVpn,
  output logic [VPN_W-1:0] tlbWrPpn,
  output logic [1:0]       tlbWrRing,
  output logic [3:0]       tlbWrAttr,
  output logic [VA_W-1:0]  excVaddr
);
  localparam int PTE_LOG2  = 2;
  localparam int PTE_SHIFT = PAGE_SHIFT - PTE_LOG2;
  localparam logic [VA_W-1:0] ALIGN_MASK = {{(VA_W-PTE_LOG2){1'b1}}, {PTE_LOG2{1'b0}}};
  localparam int RING_LSB  = 4;

  logic [VA_W-1:0]  vaddrQ, pteVaddrQ, paddrQ, excQ;
  logic             isDataQ;
  logic [31:0]      pteQ;
  logic [WAY_W-1:0] refillCntQ, refillCntInc;

  assign refillCntInc = refillCntQ + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ     <= '0;
      pteVaddrQ  <= '0;
      paddrQ     <= '0;
      isDataQ    <= 1'b0;
      pteQ       <= '0;
      refillCntQ <= '0;
      excQ       <= '0;
    end else begin
      if (strobe.captureMiss) begin
        vaddrQ    <= missVaddr;
        isDataQ   <= missIsData;
        pteVaddrQ <= (ptBase | (missVaddr >> PTE_SHIFT)) & ALIGN_MASK;
      end
      if (strobe.capturePaddr) paddrQ <= lkRspPaddr;
      if (strobe.capturePte)   pteQ   <= memRspData;
      if (strobe.commitRefill) begin
        refillCntQ <= refillCntInc;
        excQ       <= vaddrQ;
      end
    end
  end

  assign pteVaddr    = pteVaddrQ;
  assign memAddr     = paddrQ;
  assign tlbWrIsData = isDataQ;
  assign tlbWrWay    = refillCntInc;
  assign tlbWrVpn    = vaddrQ[VA_W-1:PAGE_SHIFT];
  assign tlbWrPpn    = pteQ[31:32-VPN_W];
  assign tlbWrRing   = pteQ[RING_LSB+1:RING_LSB];
  assign tlbWrAttr   = pteQ[3:0];
  assign excVaddr    = excQ;

  // R7
  way_counter_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commitRefill |=> $stable(refillCntQ));
  // R8
  exc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commitRefill |=> $stable(excQ));
  // R10
  mem_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capturePaddr |=> $stable(paddrQ));
endmodule

// File: rtl/tlb_refill_walker.sv
module tlb_refill_walker
  import walker_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_WAYS   = 4,
  localparam int VPN_W     = VA_W - PAGE_SHIFT,
  localparam int WAY_W     = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             missValid,
  input  logic [VA_W-1:0]  missVaddr,
  input  logic             missIsData,
  input  logic [VA_W-1:0]  ptBase,
  output logic             busy,
  output logic             lkReqValid,
  output logic [VA_W-1:0]  lkReqVaddr,
  input  logic             lkRspValid,
  input  logic             lkRspHit,
  input  logic [VA_W-1:0]  lkRspPaddr,
  output logic             memReqValid,
  output logic [VA_W-1:0]  memReqAddr,
  input  logic             memReqReady,
  input  logic             memRspValid,
  input  logic [31:0]      memRspData,
  output logic             tlbWrEn,
  output logic             tlbWrIsData,
  output logic [WAY_W-1:0] tlbWrWay,
  output logic [VPN_W-1:0] tlbWrVpn,
  output logic [VPN_W-1:0] tlbWrPpn,
  output logic [1:0]       tlbWrRing,
  output logic [3:0]       tlbWrAttr,
  output logic [VA_W-1:0]  excVaddr,
  output logic             doneValid,
  output logic             doneFault
);
  dpStrobe_t strobe;

  walker_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .missValid(missValid),
    .lkRspValid(lkRspValid), .lkRspHit(lkRspHit),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .strobe(strobe), .busy(busy), .lkReqValid(lkReqValid),
    .memReqValid(memReqValid), .tlbWrEn(tlbWrEn),
    .doneValid(doneValid), .doneFault(doneFault)
  );

  walker_dp #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_WAYS(NUM_WAYS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .missVaddr(missVaddr), .missIsData(missIsData), .ptBase(ptBase),
    .lkRspPaddr(lkRspPaddr), .memRspData(memRspData),
    .pteVaddr(lkReqVaddr), .memAddr(memReqAddr),
    .tlbWrIsData(tlbWrIsData), .tlbWrWay(tlbWrWay), .tlbWrVpn(tlbWrVpn),
    .tlbWrPpn(tlbWrPpn), .tlbWrRing(tlbWrRing), .tlbWrAttr(tlbWrAttr),
    .excVaddr(excVaddr)
  );
endmodule

// File: tb/test_tlb_refill_walker.sv
module test_tlb_refill_walker;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic missValid = 0, missIsData = 0;
  logic [31:0] missVaddr = 0, ptBase = 0;
  logic busy, lkReqValid, memReqValid, tlbWrEn, tlbWrIsData, doneValid, doneFault;
  logic [31:0] lkReqVaddr, memReqAddr, excVaddr;
  logic lkRspValid = 0, lkRspHit = 0, memReqReady = 0, memRspValid = 0;
  logic [31:0] lkRspPaddr = 0, memRspData = 0;
  logic [1:0] tlbWrWay, tlbWrRing;
  logic [19:0] tlbWrVpn, tlbWrPpn;
  logic [3:0] tlbWrAttr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_refill_walker i_tlb_refill_walker (.*);

  typedef struct {
    logic [31:0] va, pteVa, paddr, pte;
    logic isData, fail;
    logic [1:0] way;
  } item_t;
  item_t sbq[$];

  int checks = 0, failures = 0, doneCount = 0;
  logic probeFail = 0, finished = 0;
  int memStall = 0;
  logic [1:0] expCnt = 0;
  logic [31:0] expExc = 0;

  function automatic logic [31:0] mapPa(input logic [31:0] a);
    return a ^ 32'h4000_0000;
  endfunction
  function automatic logic [31:0] pteOf(input logic [31:0] a);
    return {a[23:4] ^ 20'h5A3C1, 6'b0, a[7:2]};
  endfunction

  task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Probe responder: answers one cycle after the request
  initial forever begin
    @(posedge clk);
    lkRspValid <= lkReqValid && !lkRspValid;
    lkRspHit   <= !probeFail;
    lkRspPaddr <= mapPa(lkReqVaddr);
  end

  // Memory responder with programmable ready delay
  initial begin
    int waitCnt = 0;
    forever begin
      @(posedge clk);
      memRspValid <= 1'b0;
      if (memReqValid && memReqReady) begin
        memReqReady <= 1'b0;
        memRspValid <= 1'b1;
        memRspData  <= pteOf(memReqAddr);
        waitCnt = 0;
      end else if (memReqValid) begin
        if (waitCnt >= memStall) memReqReady <= 1'b1;
        else waitCnt++;
      end
    end
  end

  // Monitor: pops the scoreboard when results appear
  initial begin
    logic sawProbe = 0, sawMem = 0, lastWr = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (lkReqValid && !sawProbe) begin
          sawProbe = 1;
          if (sbq.size() == 0) chk("R9 stray probe", 0, lkReqVaddr, 0);
          else chk("R2 probe address", lkReqVaddr == sbq[0].pteVa, lkReqVaddr, sbq[0].pteVa);
        end
        if (memReqValid && !sawMem && sbq.size() > 0) begin
          sawMem = 1;
          chk("R4 no memory read on failed probe", !sbq[0].fail, 1, 0);
          chk("R3 memory address", memReqAddr == sbq[0].paddr, memReqAddr, sbq[0].paddr);
        end
        if (tlbWrEn && sbq.size() > 0) begin
          chk("R4 no write on failed probe", !sbq[0].fail, 1, 0);
          chk("R7 refill way", tlbWrWay == sbq[0].way, tlbWrWay, sbq[0].way);
          chk("R5 ring", tlbWrRing == sbq[0].pte[5:4], tlbWrRing, sbq[0].pte[5:4]);
          chk("R6 ppn", tlbWrPpn == sbq[0].pte[31:12], tlbWrPpn, sbq[0].pte[31:12]);
          chk("R6 attr", tlbWrAttr == sbq[0].pte[3:0], tlbWrAttr, sbq[0].pte[3:0]);
          chk("R6 vpn", tlbWrVpn == sbq[0].va[31:12], tlbWrVpn, sbq[0].va[31:12]);
          chk("R6 side", tlbWrIsData == sbq[0].isData, tlbWrIsData, sbq[0].isData);
        end
        if (doneValid) begin
          if (sbq.size() == 0) chk("R9 stray done", 0, 1, 0);
          else begin
            chk("R4 fault flag", doneFault == sbq[0].fail, doneFault, sbq[0].fail);
            chk("R8 exception address", excVaddr == expExc, excVaddr, expExc);
            if (!sbq[0].fail) chk("R10 done one cycle after write", lastWr, lastWr, 1);
            void'(sbq.pop_front());
          end
          doneCount++;
          sawProbe = 0;
          sawMem = 0;
        end
        lastWr = tlbWrEn;
      end
    end
  end

  task automatic doMiss(input logic [31:0] va, input logic isData, input logic [31:0] base,
                        input logic fail, input int stall, input logic stray);
    item_t it;
    int startDone = doneCount;
    int cyc = 0;
    it.va = va; it.isData = isData; it.fail = fail;
    it.pteVa = (base | (va >> 10)) & 32'hFFFF_FFFC;
    it.paddr = mapPa(it.pteVa);
    it.pte = pteOf(it.paddr);
    if (!fail) begin
      expCnt = expCnt + 1;
      expExc = va;
    end
    it.way = expCnt;
    sbq.push_back(it);
    probeFail = fail;
    memStall = stall;
    @(negedge clk);
    missVaddr = va; missIsData = isData; ptBase = base; missValid = 1;
    @(negedge clk);
    missValid = 0;
    missVaddr = 32'hDEAD_BEEF; ptBase = 32'h0;
    while (doneCount == startDone) begin
      chk("R9 busy during walk", busy, busy, 1);
      @(negedge clk);
      cyc++;
      if (stray && cyc == 2) missValid = 1;
      if (stray && cyc == 3) missValid = 0;
    end
    missValid = 0;
    @(negedge clk);
    chk("R9 idle after walk", !busy, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy == 0, busy, 0);
    chk("R1 requests", {lkReqValid, memReqValid, tlbWrEn, doneValid} == 0,
        {lkReqValid, memReqValid, tlbWrEn, doneValid}, 0);
    chk("R1 excVaddr", excVaddr == 0, excVaddr, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 idle after release", busy == 0, busy, 0);
    // R7: five refills rotate ways 1,2,3,0,1
    doMiss(32'h1234_5678, 1, 32'h8000_0000, 0, 0, 0);
    doMiss(32'hA000_3FFC, 0, 32'hC000_0000, 0, 2, 0);
    doMiss(32'h0000_0000, 1, 32'h0040_0000, 0, 1, 0);
    doMiss(32'hFFFF_FFFF, 0, 32'h8000_0000, 0, 3, 0);
    doMiss(32'h7654_3210, 1, 32'h0000_0000, 0, 0, 0);
    // R4: failed probe leaves counter and excVaddr
    doMiss(32'h5555_AAAA, 1, 32'h8000_0000, 1, 0, 0);
    doMiss(32'h3333_1000, 0, 32'hE000_0000, 0, 1, 0);
    // R9: stray miss during a walk is ignored
    doMiss(32'h0BAD_F00D, 1, 32'h9000_0000, 0, 4, 1);
    doMiss(32'h2468_ACE0, 0, 32'h8000_0000, 1, 0, 1);
    doMiss(32'h1357_9BDF, 1, 32'h8800_0000, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk("R9 no leftover items", sbq.size() == 0, sbq.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule